// File: doc/BRIEF.md
# Next-PC Sequencer With One Delay Slot

This block owns the fetch address of a 32-bit RISC front end. In every cycle it sees the control class that the decoder assigned to the instruction now being fetched: plain sequential, conditional branch, absolute jump or jump through a register. It also sees the low 26 bits of that instruction word, the outcome of the branch compare and a register value. From these it chooses the address to fetch in the next cycle.

Control transfers have exactly one delay slot. The word after a taken branch or jump is always fetched. The target arrives one cycle later. All targets are built from the address of that following word, which is the current fetch address plus four. The PC register already provides this sum, so the unit never has to keep the transfer's own address. A stall freezes the whole unit. A synchronous clear sends fetch back to a fixed boot address. A separate asynchronous active-low reset is released through a synchronizer.

Top module: `npc_sequencer`

## Requirements
- R1: While the asynchronous reset is active, or in the cycle after `soft_rst` is high at a clock edge, `fetch_pc` equals `RESET_VEC` (default 0x0000_1000), and any pending redirect is dropped.
- R2: With `ctl_class` = 2'b00 (sequential) and no redirect pending, the next `fetch_pc` is the current one plus 4.
- R3: With `ctl_class` = 2'b01 (branch) and `br_taken` low, fetch continues with the current address plus 4, with no gap and nothing left pending.
- R4: A transfer decoded in cycle N is a taken branch (2'b01 with `br_taken` high), a jump (2'b10) or a register jump (2'b11). For such a transfer, `fetch_pc` is the address plus 4 (the delay slot) in cycle N+1 and the target in cycle N+2.
- R5: A branch target is (address+4) plus `instr_idx[15:0]` sign-extended and shifted left by 2. The reach is -32768 to +32767 words.
- R6: A jump target is bits [31:28] of (address+4) joined with `instr_idx[25:0]` and two zero bits. A jump in the last word of a 256 MiB region therefore lands in the next region.
- R7: A register-jump target is `reg_target` with its two low bits forced to zero.
- R8: While `stall` is high and `soft_rst` is low, `fetch_pc` and any pending target stay unchanged.
- R9: Control inputs presented while the delay slot is being fetched are ignored. The pending target is taken, and no new redirect is queued.
- R10: The two low bits of `fetch_pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_rst | input | 1 | Synchronous clear to the boot address |
| stall | input | 1 | Holds the unit when high |
| ctl_class | input | 2 | 00 sequential, 01 branch, 10 jump, 11 register jump |
| br_taken | input | 1 | Branch compare outcome |
| instr_idx | input | 26 | Low 26 bits of the instruction being fetched |
| reg_target | input | 32 | Register value for register jumps |
| fetch_pc | output | 32 | Current fetch address |

## Verification
A sequential step, an untaken branch, a stall or a clear shows on `fetch_pc` after one rising edge. A taken transfer shows its delay slot after one edge and its target after two. The bench drives inputs just after a falling edge and samples at the next falling edge. It keeps its own copy of the pending target, so each sample is compared with the value due in exactly that cycle. Directed cases cover the region-crossing jump, the extreme branch offsets, a masked register target, a stall inside a slot, and a transfer placed in a delay slot.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    CTL_SEQ = 2'b00,
    CTL_BR  = 2'b01,
    CTL_JMP = 2'b10,
    CTL_JR  = 2'b11
  } ctl_e;
endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 26,
  parameter int OFFW = 16
) (
  input  logic [AW-1:0]   pc,
  input  ctl_e            ctl,
  input  logic            br_taken,
  input  logic [IDXW-1:0] instr_idx,
  input  logic [AW-1:0]   reg_target,
  output logic [AW-1:0]   seq_pc,
  output logic [AW-1:0]   target,
  output logic            take
);
  localparam int SEXT_W   = AW - OFFW - 2;
  localparam int REGION_W = AW - IDXW - 2;
  localparam logic [AW-1:0] ALIGN_MASK = {{(AW-2){1'b1}}, 2'b00};

  logic [AW-1:0] br_off;
  logic [AW-1:0] br_tgt;
  logic [AW-1:0] jmp_tgt;
  logic [AW-1:0] jr_tgt;

  assign seq_pc  = pc + AW'(4);
  assign br_off  = {{SEXT_W{instr_idx[OFFW-1]}}, instr_idx[OFFW-1:0], 2'b00};
  assign br_tgt  = seq_pc + br_off;
  assign jmp_tgt = {seq_pc[AW-1 -: REGION_W], instr_idx, 2'b00};
  assign jr_tgt  = reg_target & ALIGN_MASK;

  always_comb begin
    target = br_tgt;
    take   = 1'b0;
    unique case (ctl)
      CTL_SEQ: begin target = seq_pc;  take = 1'b0;     end
      CTL_BR:  begin target = br_tgt;  take = br_taken; end
      CTL_JMP: begin target = jmp_tgt; take = 1'b1;     end
      CTL_JR:  begin target = jr_tgt;  take = 1'b1;     end
      default: begin target = seq_pc;  take = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/npc_slot_ctrl.sv
module npc_slot_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          advance,
  input  logic          take,
  input  logic [AW-1:0] target,
  output logic          pend_valid,
  output logic [AW-1:0] pend_target
);
  logic          pv_d;
  logic [AW-1:0] pt_d;
  logic          slot_en;

  assign slot_en = soft_rst | advance;

  always_comb begin
    pv_d = pend_valid;
    pt_d = pend_target;
    if (soft_rst) begin
      pv_d = 1'b0;
    end else if (advance) begin
      if (pend_valid) begin
        pv_d = 1'b0;
      end else if (take) begin
        pv_d = 1'b1;
        pt_d = target;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid  <= 1'b0;
      pend_target <= '0;
    end else if (slot_en) begin
      pend_valid  <= pv_d;
      pend_target <= pt_d;
    end
  end
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IDXW        = 26,
  parameter int OFFW        = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            stall,
  input  logic [1:0]      ctl_class,
  input  logic            br_taken,
  input  logic [IDXW-1:0] instr_idx,
  input  logic [AW-1:0]   reg_target,
  output logic [AW-1:0]   fetch_pc
);
  logic          rst_sync_n;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic          pc_en;
  logic          advance;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] xfer_target;
  logic          xfer_take;
  logic          pend_valid;
  logic [AW-1:0] pend_target;

  npc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_target_calc #(.AW(AW), .IDXW(IDXW), .OFFW(OFFW)) u_calc (
    .pc         (pc_q),
    .ctl        (ctl_e'(ctl_class)),
    .br_taken   (br_taken),
    .instr_idx  (instr_idx),
    .reg_target (reg_target),
    .seq_pc     (seq_pc),
    .target     (xfer_target),
    .take       (xfer_take)
  );

  npc_slot_ctrl #(.AW(AW)) u_slot (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .soft_rst    (soft_rst),
    .advance     (advance),
    .take        (xfer_take),
    .target      (xfer_target),
    .pend_valid  (pend_valid),
    .pend_target (pend_target)
  );

  assign advance = ~stall;
  assign pc_en   = soft_rst | advance;

  always_comb begin
    pc_d = pc_q;
    if (soft_rst)        pc_d = RESET_VEC;
    else if (pend_valid) pc_d = pend_target;
    else                 pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= RESET_VEC;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          soft_rst,
  input logic          stall,
  input logic [1:0]    ctl_class,
  input logic          br_taken,
  input logic [AW-1:0] fetch_pc,
  input logic          pend_valid,
  input logic [AW-1:0] pend_target
);
  logic go;
  logic xfer;
  assign go   = ~soft_rst & ~stall;
  assign xfer = ctl_class[1] | (ctl_class[0] & br_taken);

  assert_reset_vec_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |=> (fetch_pc == RESET_VEC) && !pend_valid);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && !pend_valid && ctl_class == 2'b00) |=> fetch_pc == $past(fetch_pc) + AW'(4));

  assert_untaken_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && !pend_valid && ctl_class == 2'b01 && !br_taken)
      |=> (fetch_pc == $past(fetch_pc) + AW'(4)) && !pend_valid);

  assert_delay_slot_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && !pend_valid && xfer) |=> (fetch_pc == $past(fetch_pc) + AW'(4)) && pend_valid);

  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && pend_valid) |=> fetch_pc == $past(pend_target));

  assert_slot_ignored_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && pend_valid) |=> !pend_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stall && !soft_rst) |=> $stable(fetch_pc) && $stable(pend_valid) && $stable(pend_target));

  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_pc[1:0] == 2'b00) && (!pend_valid || pend_target[1:0] == 2'b00));
endmodule

bind npc_sequencer npc_sequencer_chk #(.AW(AW), .RESET_VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .soft_rst    (soft_rst),
  .stall       (stall),
  .ctl_class   (ctl_class),
  .br_taken    (br_taken),
  .fetch_pc    (fetch_pc),
  .pend_valid  (pend_valid),
  .pend_target (pend_target)
);

// File: tb/sim_npc_sequencer.sv
module sim_npc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'h0000_1000;
  localparam int RANDOM_CYCLES = 4000;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        stall = 1'b0;
  logic [1:0]  ctl_class = 2'b00;
  logic        br_taken = 1'b0;
  logic [25:0] instr_idx = '0;
  logic [31:0] reg_target = '0;
  logic [31:0] fetch_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_pc = RV;
  logic [31:0] m_pt = '0;
  logic        m_pv = 1'b0;
  string       m_ptag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_sequencer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .stall      (stall),
    .ctl_class  (ctl_class),
    .br_taken   (br_taken),
    .instr_idx  (instr_idx),
    .reg_target (reg_target),
    .fetch_pc   (fetch_pc)
  );

  function automatic logic [31:0] exp_target(input logic [1:0] c, input logic [31:0] pc4,
                                             input logic [25:0] ix, input logic [31:0] rt);
    case (c)
      2'b01:   return pc4 + {{14{ix[15]}}, ix[15:0], 2'b00};
      2'b10:   return {pc4[31:28], ix, 2'b00};
      default: return {rt[31:2], 2'b00};
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: fetch_pc actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic st, input logic [1:0] c, input logic t,
                     input logic [25:0] ix, input logic [31:0] rt);
    string tag;
    soft_rst = s; stall = st; ctl_class = c; br_taken = t; instr_idx = ix; reg_target = rt;
    if (s) begin
      m_pc = RV; m_pv = 1'b0; tag = "R1";
    end else if (st) begin
      tag = "R8";
    end else if (m_pv) begin
      m_pc = m_pt; m_pv = 1'b0;
      tag = (c != 2'b00) ? "R9" : m_ptag;
    end else begin
      if (c == 2'b00) tag = "R2";
      else if (c == 2'b01 && !t) tag = "R3";
      else begin
        m_pv = 1'b1;
        m_pt = exp_target(c, m_pc + 32'd4, ix, rt);
        m_ptag = (c == 2'b01) ? "R5" : (c == 2'b10) ? "R6" : "R7";
        tag = "R4";
      end
      m_pc = m_pc + 32'd4;
    end
    @(negedge clk);
    check(fetch_pc, m_pc, tag);
    check({30'd0, fetch_pc[1:0]}, 32'd0, "R10");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(fetch_pc, RV, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(fetch_pc, RV, "R1");

    // Register jump with low bits set: delay slot, then masked target (R7)
    cyc(0, 0, 2'b11, 0, '0, 32'h0FFF_FFFB);
    check(fetch_pc, RV + 32'd4, "R4");
    cyc(0, 0, 2'b00, 0, '0, '0);
    check(fetch_pc, 32'h0FFF_FFF8, "R7");
    cyc(0, 0, 2'b00, 0, '0, '0);
    // Jump in last word of region: target lies in the next region (R6)
    cyc(0, 0, 2'b10, 0, 26'h10, '0);
    check(fetch_pc, 32'h1000_0000, "R4");
    cyc(0, 0, 2'b00, 0, '0, '0);
    check(fetch_pc, 32'h1000_0040, "R6");
    // Most negative branch offset, stall in slot, jump in slot ignored (R5 R8 R9)
    cyc(0, 0, 2'b01, 1, 26'h8000, '0);
    cyc(0, 1, 2'b00, 0, '0, '0);
    check(fetch_pc, 32'h1000_0044, "R8");
    cyc(0, 0, 2'b10, 0, 26'h3FF_FFFF, '0);
    check(fetch_pc, 32'h0FFE_0044, "R5");
    cyc(0, 0, 2'b00, 0, '0, '0);
    check(fetch_pc, 32'h0FFE_0048, "R9");
    // Untaken branch
    cyc(0, 0, 2'b01, 0, 26'h7FFF, '0);
    check(fetch_pc, 32'h0FFE_004C, "R3");
    // Soft clear drops a pending redirect
    cyc(0, 0, 2'b10, 0, 26'h123, '0);
    cyc(1, 0, 2'b00, 0, '0, '0);
    check(fetch_pc, RV, "R1");
    cyc(0, 0, 2'b00, 0, '0, '0);
    check(fetch_pc, RV + 32'd4, "R1");
    // Most positive branch offset
    cyc(0, 0, 2'b01, 1, 26'h7FFF, '0);
    cyc(0, 0, 2'b00, 0, '0, '0);
    check(fetch_pc, RV + 32'd8 + 32'h0001_FFFC, "R5");

    for (int i = 0; i < RANDOM_CYCLES; i++) begin
      logic s, st, t;
      logic [1:0] c;
      s  = ($urandom % 40) == 0;
      st = ($urandom % 8) == 0;
      c  = 2'($urandom);
      t  = 1'($urandom);
      cyc(s, st, c, t, 26'($urandom), $urandom);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule